// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block gathers interrupt events for a transmit engine with up to ten queues. Each per-queue event pulse (completion, descriptor request, error, end of list, underrun, constant-bit-rate overrun and underrun, scheduling trigger) sets a sticky bit in one of five secondary status registers. Host-bus error events and beacon-timing events also land in a secondary register. A primary status register presents one summary bit per group, computed live as the OR of the secondary bits behind it, next to a handful of direct sticky event bits.

Software reads the registers over a simple read/write port and clears bits by writing ones (write-one-to-clear). A write of one to a summary bit in the primary register wipes every secondary bit that feeds that summary, across all queues. Careful software therefore clears through the secondary registers, so that an event arriving during servicing is not lost. A mask register selects which primary bits raise the single interrupt output.

Top module: `irqagg_top`

## Requirements
- R1: A synchronous active-low reset clears every status register and the mask; after it `irq` and `reg_rvalid` are 0 and every register reads 0.
- R2: Per-queue pulses set sticky bits, with queue q at bit q of the low field (bits NQ-1:0) or bit 16+q of the high field: secondary 0 holds completion (low) and descriptor request (high), secondary 1 holds error (low) and end of list (high), secondary 2 holds underrun (low), secondary 3 holds CBR overrun (low) and CBR underrun (high), secondary 4 holds scheduling trigger (low).
- R3: Secondary 2 also holds single bits: `ev_bus[0..2]` set bits 20, 21, 22 (master abort, system error, parity error); `ev_bcn[0..6]` set bits 23, 24, 25, 27, 28, 29, 31 (CAB end, DTIM sync, TIM, beacon timeout, CAB timeout, DTIM, TSF out of range). Unlisted bits of every register read 0.
- R4: Primary summary bits are live ORs: bit 6 of secondary 0 low, bit 7 of secondary 0 high, bit 8 of secondary 1 low, bit 10 of secondary 1 high, bit 11 of secondary 2 low, bit 19 of secondary 2 bits 22:20, bit 23 of the six beacon bits 23..29 (not bit 31), bit 25 of secondary 3 low, bit 26 of secondary 3 high, bit 27 of secondary 4 low.
- R5: `ev_direct[0..3]` set sticky primary bits 12, 16, 18, 24.
- R6: Writing a register clears exactly the bits written as one; bits written as zero keep their value. This holds for secondary registers and for the direct primary bits.
- R7: Writing one to a primary summary bit clears every secondary bit feeding it; writing bit 23 leaves secondary 2 bit 31 untouched.
- R8: When an event and a clear of the same bit meet in one cycle, the bit ends set.
- R9: `irq` is high exactly when some primary bit is set whose mask bit is set; the mask is read/write at address 6 and status bits keep latching while masked.
- R10: Address map: 0 primary, 1 to 5 secondary 0 to 4, 6 mask, 7 reads 0 and ignores writes. A read returns data with `reg_rvalid` one cycle after `reg_rd`, holds the value before any same-cycle write, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_txok | input | NQ | Per-queue completion pulses |
| ev_txdesc | input | NQ | Per-queue descriptor-request pulses |
| ev_txerr | input | NQ | Per-queue error pulses |
| ev_txeol | input | NQ | Per-queue end-of-list pulses |
| ev_txurn | input | NQ | Per-queue underrun pulses |
| ev_cbrovr | input | NQ | Per-queue CBR overrun pulses |
| ev_cbrund | input | NQ | Per-queue CBR underrun pulses |
| ev_qtrig | input | NQ | Per-queue scheduling-trigger pulses |
| ev_bus | input | 3 | Host-bus error pulses |
| ev_bcn | input | 7 | Beacon-timing pulses |
| ev_direct | input | 4 | Direct primary event pulses |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data (ones clear status bits) |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench aims at a clear and an event colliding on one bit, where a design giving priority to the clear would silently drop an event. It clears a summary bit in the primary register and checks that all queues of the feeding field empty while unrelated fields survive, and that the TSF out-of-range bit outlives a beacon-summary clear; a design that mapped the summary clear wrongly would either leave stale bits or erase foreign ones. It reads and writes one register in the same cycle to catch a read path that returns post-write data. It also confirms that masked events still latch and raise `irq` once unmasked.

// File: rtl/irqagg_pkg.sv
// Package: shared constants for the interrupt status aggregator.
// Holds the address map, bit positions and field mask helpers.
// Assumes 32-bit registers and at most 16 queues per field.
package irqagg_pkg;

    localparam int REG_W  = 32;
    localparam int NSEC   = 5;
    localparam int HI_OFS = 16;

    localparam logic [2:0] ADDR_PRIM = 3'd0;
    localparam logic [2:0] ADDR_SEC0 = 3'd1;
    localparam logic [2:0] ADDR_MASK = 3'd6;

    // Primary summary bit positions (decoded by software)
    localparam int P_TXOK   = 6;
    localparam int P_TXDESC = 7;
    localparam int P_TXERR  = 8;
    localparam int P_TXEOL  = 10;
    localparam int P_TXURN  = 11;
    localparam int P_HOSTER = 19;
    localparam int P_BCNSUM = 23;
    localparam int P_CBROVR = 25;
    localparam int P_CBRUND = 26;
    localparam int P_QTRIG  = 27;

    // Direct primary bits
    localparam int P_MIB    = 12;
    localparam int P_SWBA   = 16;
    localparam int P_BMISS  = 18;
    localparam int P_GPIO   = 24;

    // Secondary 2 single-bit positions
    localparam int S2_MABT   = 20;
    localparam int S2_SERR   = 21;
    localparam int S2_PERR   = 22;
    localparam int S2_CABEND = 23;
    localparam int S2_DTSYNC = 24;
    localparam int S2_TIM    = 25;
    localparam int S2_BCNTO  = 27;
    localparam int S2_CABTO  = 28;
    localparam int S2_DTIM   = 29;
    localparam int S2_TSFOOR = 31;

    localparam logic [REG_W-1:0] HOSTER_BITS =
        (32'd1 << S2_MABT) | (32'd1 << S2_SERR) | (32'd1 << S2_PERR);
    localparam logic [REG_W-1:0] BCN_BITS =
        (32'd1 << S2_CABEND) | (32'd1 << S2_DTSYNC) | (32'd1 << S2_TIM) |
        (32'd1 << S2_BCNTO)  | (32'd1 << S2_CABTO)  | (32'd1 << S2_DTIM);
    localparam logic [REG_W-1:0] TSF_BIT = 32'd1 << S2_TSFOOR;
    localparam logic [REG_W-1:0] DIR_BITS =
        (32'd1 << P_MIB) | (32'd1 << P_SWBA) | (32'd1 << P_BMISS) | (32'd1 << P_GPIO);

    // Low per-queue field mask for nq queues
    function automatic logic [REG_W-1:0] lo_field(input int nq);
        return REG_W'((64'd1 << nq) - 64'd1);
    endfunction

    // High per-queue field mask for nq queues
    function automatic logic [REG_W-1:0] hi_field(input int nq);
        return lo_field(nq) << HI_OFS;
    endfunction

    // Implemented bits of secondary register idx
    function automatic logic [REG_W-1:0] sec_impl(input int idx, input int nq);
        case (idx)
            0, 1, 3: return lo_field(nq) | hi_field(nq);
            2:       return lo_field(nq) | HOSTER_BITS | BCN_BITS | TSF_BIT;
            default: return lo_field(nq);
        endcase
    endfunction

endpackage

// File: rtl/irqagg_w1c_reg.sv
// Module: one sticky write-one-to-clear status register.
// A set in the same cycle as a clear wins. Bits outside IMPL stay zero.
// Assumes set and clear vectors are single-cycle strobes.
module irqagg_w1c_reg #(
    parameter int            W    = 32,
    parameter logic [W-1:0]  IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    // Update sticky bits: clear written ones, then apply new events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= ((q_o & ~clr_i) | set_i) & IMPL;
        end
    end

endmodule

// File: rtl/irqagg_decode.sv
// Module: maps event pulses onto register bit positions and turns
// register writes into per-register clear vectors. A one written to a
// primary summary bit expands into the full set of feeding bits.
// Assumes NQ <= 16. Purely combinational.
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int NQ = 10
) (
    input  logic [NQ-1:0]               ev_txok,
    input  logic [NQ-1:0]               ev_txdesc,
    input  logic [NQ-1:0]               ev_txerr,
    input  logic [NQ-1:0]               ev_txeol,
    input  logic [NQ-1:0]               ev_txurn,
    input  logic [NQ-1:0]               ev_cbrovr,
    input  logic [NQ-1:0]               ev_cbrund,
    input  logic [NQ-1:0]               ev_qtrig,
    input  logic [2:0]                  ev_bus,
    input  logic [6:0]                  ev_bcn,
    input  logic [3:0]                  ev_direct,
    input  logic                        reg_wr,
    input  logic [2:0]                  reg_addr,
    input  logic [REG_W-1:0]            reg_wdata,
    output logic [NSEC-1:0][REG_W-1:0]  sec_set,
    output logic [NSEC-1:0][REG_W-1:0]  sec_clr,
    output logic [REG_W-1:0]            dir_set,
    output logic [REG_W-1:0]            dir_clr,
    output logic                        mask_we
);

    localparam logic [REG_W-1:0] LO = lo_field(NQ);
    localparam logic [REG_W-1:0] HI = hi_field(NQ);

    logic prim_wr;

    assign prim_wr = reg_wr && (reg_addr == ADDR_PRIM);
    assign mask_we = reg_wr && (reg_addr == ADDR_MASK);

    // Place per-queue and single-bit events into secondary registers
    always_comb begin
        sec_set = '0;
        for (int q = 0; q < NQ; q++) begin
            sec_set[0][q]          = ev_txok[q];
            sec_set[0][HI_OFS + q] = ev_txdesc[q];
            sec_set[1][q]          = ev_txerr[q];
            sec_set[1][HI_OFS + q] = ev_txeol[q];
            sec_set[2][q]          = ev_txurn[q];
            sec_set[3][q]          = ev_cbrovr[q];
            sec_set[3][HI_OFS + q] = ev_cbrund[q];
            sec_set[4][q]          = ev_qtrig[q];
        end
        sec_set[2][S2_MABT]   = ev_bus[0];
        sec_set[2][S2_SERR]   = ev_bus[1];
        sec_set[2][S2_PERR]   = ev_bus[2];
        sec_set[2][S2_CABEND] = ev_bcn[0];
        sec_set[2][S2_DTSYNC] = ev_bcn[1];
        sec_set[2][S2_TIM]    = ev_bcn[2];
        sec_set[2][S2_BCNTO]  = ev_bcn[3];
        sec_set[2][S2_CABTO]  = ev_bcn[4];
        sec_set[2][S2_DTIM]   = ev_bcn[5];
        sec_set[2][S2_TSFOOR] = ev_bcn[6];
    end

    // Place direct events into the primary register
    always_comb begin
        dir_set = '0;
        dir_set[P_MIB]   = ev_direct[0];
        dir_set[P_SWBA]  = ev_direct[1];
        dir_set[P_BMISS] = ev_direct[2];
        dir_set[P_GPIO]  = ev_direct[3];
    end

    // Build clear vectors from direct writes and summary-bit expansion
    always_comb begin
        for (int i = 0; i < NSEC; i++) begin
            sec_clr[i] = (reg_wr && (reg_addr == 3'(i + 1))) ? reg_wdata : '0;
        end
        if (prim_wr) begin
            if (reg_wdata[P_TXOK])   sec_clr[0] = sec_clr[0] | LO;
            if (reg_wdata[P_TXDESC]) sec_clr[0] = sec_clr[0] | HI;
            if (reg_wdata[P_TXERR])  sec_clr[1] = sec_clr[1] | LO;
            if (reg_wdata[P_TXEOL])  sec_clr[1] = sec_clr[1] | HI;
            if (reg_wdata[P_TXURN])  sec_clr[2] = sec_clr[2] | LO;
            if (reg_wdata[P_HOSTER]) sec_clr[2] = sec_clr[2] | HOSTER_BITS;
            if (reg_wdata[P_BCNSUM]) sec_clr[2] = sec_clr[2] | BCN_BITS;
            if (reg_wdata[P_CBROVR]) sec_clr[3] = sec_clr[3] | LO;
            if (reg_wdata[P_CBRUND]) sec_clr[3] = sec_clr[3] | HI;
            if (reg_wdata[P_QTRIG])  sec_clr[4] = sec_clr[4] | LO;
        end
        dir_clr = prim_wr ? (reg_wdata & DIR_BITS) : '0;
    end

endmodule

// File: rtl/irqagg_summary.sv
// Module: forms the primary status word from the direct sticky bits and
// live OR-reductions of the secondary registers. No storage of its own,
// so a summary bit drops as soon as its feeding bits are cleared.
module irqagg_summary
    import irqagg_pkg::*;
#(
    parameter int NQ = 10
) (
    input  logic [NSEC-1:0][REG_W-1:0] sec_q,
    input  logic [REG_W-1:0]           dir_q,
    output logic [REG_W-1:0]           prim
);

    localparam logic [REG_W-1:0] LO = lo_field(NQ);
    localparam logic [REG_W-1:0] HI = hi_field(NQ);

    // Combine direct bits with the per-group summaries
    always_comb begin
        prim           = dir_q & DIR_BITS;
        prim[P_TXOK]   = |(sec_q[0] & LO);
        prim[P_TXDESC] = |(sec_q[0] & HI);
        prim[P_TXERR]  = |(sec_q[1] & LO);
        prim[P_TXEOL]  = |(sec_q[1] & HI);
        prim[P_TXURN]  = |(sec_q[2] & LO);
        prim[P_HOSTER] = |(sec_q[2] & HOSTER_BITS);
        prim[P_BCNSUM] = |(sec_q[2] & BCN_BITS);
        prim[P_CBROVR] = |(sec_q[3] & LO);
        prim[P_CBRUND] = |(sec_q[3] & HI);
        prim[P_QTRIG]  = |(sec_q[4] & LO);
    end

endmodule

// File: rtl/irqagg_regport.sv
// Module: register read path, interrupt mask and interrupt output.
// Reads are registered (one cycle latency) and have no side effects.
// Assumes address decode of writes to the mask is done upstream.
module irqagg_regport
    import irqagg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_rd,
    input  logic [2:0]                 reg_addr,
    input  logic [REG_W-1:0]           reg_wdata,
    input  logic                       mask_we,
    input  logic [REG_W-1:0]           prim,
    input  logic [NSEC-1:0][REG_W-1:0] sec_q,
    output logic [REG_W-1:0]           reg_rdata,
    output logic                       reg_rvalid,
    output logic [REG_W-1:0]           mask_q,
    output logic                       irq
);

    logic [REG_W-1:0] rd_mux;

    // Hold the interrupt mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= reg_wdata;
        end
    end

    // Select the addressed register value
    always_comb begin
        case (reg_addr)
            ADDR_PRIM: rd_mux = prim;
            3'd1:      rd_mux = sec_q[0];
            3'd2:      rd_mux = sec_q[1];
            3'd3:      rd_mux = sec_q[2];
            3'd4:      rd_mux = sec_q[3];
            3'd5:      rd_mux = sec_q[4];
            ADDR_MASK: rd_mux = mask_q;
            default:   rd_mux = '0;
        endcase
    end

    // Register read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                reg_rdata <= rd_mux;
            end
        end
    end

    // Raise the interrupt for any unmasked primary bit
    assign irq = |(prim & mask_q);

endmodule

// File: rtl/irqagg_top.sv
// Module: two-level interrupt status aggregator for a multi-queue
// transmit engine. Five secondary sticky registers collect events,
// a primary word summarises them, software clears by writing ones.
// Assumes NQ <= 16 and single-cycle event pulses.
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NQ = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    ev_txok,
    input  logic [NQ-1:0]    ev_txdesc,
    input  logic [NQ-1:0]    ev_txerr,
    input  logic [NQ-1:0]    ev_txeol,
    input  logic [NQ-1:0]    ev_txurn,
    input  logic [NQ-1:0]    ev_cbrovr,
    input  logic [NQ-1:0]    ev_cbrund,
    input  logic [NQ-1:0]    ev_qtrig,
    input  logic [2:0]       ev_bus,
    input  logic [6:0]       ev_bcn,
    input  logic [3:0]       ev_direct,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             reg_rvalid,
    output logic             irq
);

    logic [NSEC-1:0][REG_W-1:0] sec_set;
    logic [NSEC-1:0][REG_W-1:0] sec_clr;
    logic [NSEC-1:0][REG_W-1:0] sec_q;
    logic [REG_W-1:0]           dir_set;
    logic [REG_W-1:0]           dir_clr;
    logic [REG_W-1:0]           dir_q;
    logic [REG_W-1:0]           prim;
    logic [REG_W-1:0]           mask_q;
    logic                       mask_we;

    irqagg_decode #(.NQ(NQ)) u_decode (
        .ev_txok   (ev_txok),
        .ev_txdesc (ev_txdesc),
        .ev_txerr  (ev_txerr),
        .ev_txeol  (ev_txeol),
        .ev_txurn  (ev_txurn),
        .ev_cbrovr (ev_cbrovr),
        .ev_cbrund (ev_cbrund),
        .ev_qtrig  (ev_qtrig),
        .ev_bus    (ev_bus),
        .ev_bcn    (ev_bcn),
        .ev_direct (ev_direct),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sec_set   (sec_set),
        .sec_clr   (sec_clr),
        .dir_set   (dir_set),
        .dir_clr   (dir_clr),
        .mask_we   (mask_we)
    );

    // One sticky register per secondary status word
    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        irqagg_w1c_reg #(
            .W    (REG_W),
            .IMPL (sec_impl(g, NQ))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (sec_set[g]),
            .clr_i (sec_clr[g]),
            .q_o   (sec_q[g])
        );
    end

    irqagg_w1c_reg #(
        .W    (REG_W),
        .IMPL (DIR_BITS)
    ) u_direct (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (dir_set),
        .clr_i (dir_clr),
        .q_o   (dir_q)
    );

    irqagg_summary #(.NQ(NQ)) u_summary (
        .sec_q (sec_q),
        .dir_q (dir_q),
        .prim  (prim)
    );

    irqagg_regport u_regport (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .mask_we    (mask_we),
        .prim       (prim),
        .sec_q      (sec_q),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .mask_q     (mask_q),
        .irq        (irq)
    );

endmodule

// File: rtl/irqagg_chk.sv
// Module: assertion checker for irqagg_top, attached by bind.
// Watches the port signals plus secondary 0, the completion summary
// bit and the mask register.
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int NQ = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NQ-1:0]    ev_txok,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             reg_rvalid,
    input logic             irq,
    input logic [31:0]      sec0,
    input logic             prim_txok,
    input logic [31:0]      mask_q
);

    // R1: reset leaves everything cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sec0 == '0 && mask_q == '0 && !irq && !reg_rvalid));

    // R2: a completion pulse leaves its queue bit set
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_txok) |=> ((sec0[NQ-1:0] & $past(ev_txok)) == $past(ev_txok)));

    // R4: completion summary follows its secondary field
    p_summary_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prim_txok == (|sec0[NQ-1:0]));

    // R6: bits written as zero to secondary 0 keep their value
    p_w1c_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_SEC0) |=>
        ((($past(sec0) & ~$past(reg_wdata)) & ~sec0) == '0));

    // R7: summary clear empties the whole completion field
    p_summary_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_PRIM && reg_wdata[P_TXOK] && ev_txok == '0) |=>
        (sec0[NQ-1:0] == '0));

    // R8: event beats a same-cycle clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_txok[0] && reg_wr && reg_addr == ADDR_SEC0 && reg_wdata[0]) |=> sec0[0]);

    // R9: a zero mask keeps the interrupt low
    p_mask_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R10: read data valid one cycle after a read strobe
    p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    // R10: no valid without a read strobe
    p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

endmodule

bind irqagg_top irqagg_chk #(.NQ(NQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_txok    (ev_txok),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .irq        (irq),
    .sec0       (sec_q[0]),
    .prim_txok  (prim[6]),
    .mask_q     (mask_q)
);

// File: tb/irqagg_top_test.sv
// Bench: directed corner cases followed by seeded random traffic,
// compared against a reference model built from the requirements.
module irqagg_top_test;

    localparam int NQ = 10;
    localparam logic [31:0] LO  = 32'h0000_03FF;
    localparam logic [31:0] HI  = 32'h03FF_0000;
    localparam logic [31:0] BUS = 32'h0070_0000;
    localparam logic [31:0] BCN = 32'h3B80_0000;
    localparam logic [31:0] DIR = 32'h0105_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NQ-1:0] ev_txok = '0, ev_txdesc = '0, ev_txerr = '0, ev_txeol = '0;
    logic [NQ-1:0] ev_txurn = '0, ev_cbrovr = '0, ev_cbrund = '0, ev_qtrig = '0;
    logic [2:0]    ev_bus = '0;
    logic [6:0]    ev_bcn = '0;
    logic [3:0]    ev_direct = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_rvalid, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqagg_top #(.NQ(NQ)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_txok(ev_txok), .ev_txdesc(ev_txdesc), .ev_txerr(ev_txerr),
        .ev_txeol(ev_txeol), .ev_txurn(ev_txurn), .ev_cbrovr(ev_cbrovr),
        .ev_cbrund(ev_cbrund), .ev_qtrig(ev_qtrig), .ev_bus(ev_bus),
        .ev_bcn(ev_bcn), .ev_direct(ev_direct),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq(irq)
    );

    // Reference model state
    logic [31:0] m_sec [5];
    logic [31:0] m_dir, m_mask, m_rdata;
    logic        m_rvalid;

    function automatic logic [31:0] m_prim();
        logic [31:0] p;
        p = m_dir;
        p[6]  = |(m_sec[0] & LO);
        p[7]  = |(m_sec[0] & HI);
        p[8]  = |(m_sec[1] & LO);
        p[10] = |(m_sec[1] & HI);
        p[11] = |(m_sec[2] & LO);
        p[19] = |(m_sec[2] & BUS);
        p[23] = |(m_sec[2] & BCN);
        p[25] = |(m_sec[3] & LO);
        p[26] = |(m_sec[3] & HI);
        p[27] = |(m_sec[4] & LO);
        return p;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_prim();
            3'd6:    return m_mask;
            3'd7:    return 32'h0;
            default: return m_sec[a - 3'd1];
        endcase
    endfunction

    // Model update at each rising edge
    always @(posedge clk) begin
        logic [31:0] st [5];
        logic [31:0] cl [5];
        logic [31:0] dset;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) m_sec[i] <= '0;
            m_dir <= '0; m_mask <= '0; m_rdata <= '0; m_rvalid <= 1'b0;
        end else begin
            st[0] = 32'(ev_txok) | (32'(ev_txdesc) << 16);
            st[1] = 32'(ev_txerr) | (32'(ev_txeol) << 16);
            st[2] = 32'(ev_txurn) | (32'(ev_bus) << 20) |
                    {ev_bcn[6], 1'b0, ev_bcn[5:3], 1'b0, ev_bcn[2:0], 23'b0};
            st[3] = 32'(ev_cbrovr) | (32'(ev_cbrund) << 16);
            st[4] = 32'(ev_qtrig);
            dset  = (32'(ev_direct[0]) << 12) | (32'(ev_direct[1]) << 16) |
                    (32'(ev_direct[2]) << 18) | (32'(ev_direct[3]) << 24);
            for (int i = 0; i < 5; i++)
                cl[i] = (reg_wr && reg_addr == 3'(i + 1)) ? reg_wdata : 32'h0;
            if (reg_wr && reg_addr == 3'd0) begin
                if (reg_wdata[6])  cl[0] |= LO;
                if (reg_wdata[7])  cl[0] |= HI;
                if (reg_wdata[8])  cl[1] |= LO;
                if (reg_wdata[10]) cl[1] |= HI;
                if (reg_wdata[11]) cl[2] |= LO;
                if (reg_wdata[19]) cl[2] |= BUS;
                if (reg_wdata[23]) cl[2] |= BCN;
                if (reg_wdata[25]) cl[3] |= LO;
                if (reg_wdata[26]) cl[3] |= HI;
                if (reg_wdata[27]) cl[4] |= LO;
                m_dir <= (m_dir & ~(reg_wdata & DIR)) | dset;
            end else begin
                m_dir <= m_dir | dset;
            end
            for (int i = 0; i < 5; i++) m_sec[i] <= (m_sec[i] & ~cl[i]) | st[i];
            if (reg_wr && reg_addr == 3'd6) m_mask <= reg_wdata;
            m_rvalid <= reg_rd;
            if (reg_rd) m_rdata <= m_read(reg_addr);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_events();
        ev_txok = '0; ev_txdesc = '0; ev_txerr = '0; ev_txeol = '0;
        ev_txurn = '0; ev_cbrovr = '0; ev_cbrund = '0; ev_qtrig = '0;
        ev_bus = '0; ev_bcn = '0; ev_direct = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; clear_events();
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
        chk(reg_rvalid && reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20250611));
        repeat (3) tick();
        chk(!irq && !reg_rvalid, "R1 outputs in reset", {30'b0, irq, reg_rvalid}, 32'h0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R1 register after reset");

        // R2 / R4: queue fields and live summary
        ev_txok = 10'h201; tick(); clear_events();
        rd_chk(3'd1, 32'h0000_0201, "R2 completion field");
        rd_chk(3'd0, 32'h0000_0040, "R4 completion summary");
        ev_txdesc = 10'h004; tick(); clear_events();
        rd_chk(3'd1, 32'h0004_0201, "R2 descriptor field");
        rd_chk(3'd0, 32'h0000_00C0, "R4 two summaries");

        // R6: write one clears only that bit
        wr(3'd1, 32'h0000_0001);
        rd_chk(3'd1, 32'h0004_0200, "R6 secondary w1c");

        // R7 + R8: summary clear colliding with a new event
        ev_txok = 10'h008; wr(3'd0, 32'h0000_0040);
        rd_chk(3'd1, 32'h0004_0008, "R8 set wins over summary clear");
        wr(3'd0, 32'h0000_0040);
        rd_chk(3'd1, 32'h0004_0000, "R7 summary clear empties field");
        rd_chk(3'd0, 32'h0000_0080, "R7 summary drops");

        // R8 on a secondary write
        ev_txerr = 10'h020; wr(3'd2, 32'h0000_0020);
        rd_chk(3'd2, 32'h0000_0020, "R8 set wins over secondary clear");

        // R3: bus and beacon bits
        ev_bcn = 7'h7F; ev_bus = 3'b111; ev_txurn = 10'h3FF; tick(); clear_events();
        rd_chk(3'd3, 32'hBBF0_03FF, "R3 secondary 2 layout");
        rd_chk(3'd0, 32'h0088_0980, "R4 host error and beacon summaries");
        wr(3'd0, 32'h0088_0000);
        rd_chk(3'd3, 32'h8000_03FF, "R7 beacon clear keeps TSF bit");

        // R5: direct bits
        ev_direct = 4'hF; tick(); clear_events();
        rd_chk(3'd0, 32'h0105_1980, "R5 direct bits");
        wr(3'd0, 32'h0001_0000);
        rd_chk(3'd0, 32'h0104_1980, "R6 direct w1c");

        // R2: CBR and trigger fields
        ev_cbrovr = 10'h001; ev_cbrund = 10'h200; ev_qtrig = 10'h010; tick(); clear_events();
        rd_chk(3'd4, 32'h0200_0001, "R2 CBR fields");
        rd_chk(3'd5, 32'h0000_0010, "R2 trigger field");
        rd_chk(3'd0, 32'h0F04_1980, "R4 CBR and trigger summaries");

        // R9: mask behaviour
        wr(3'd6, 32'h0004_0000);
        chk(irq, "R9 unmasked bit raises irq", {31'b0, irq}, 32'h1);
        rd_chk(3'd6, 32'h0004_0000, "R9 mask readback");
        wr(3'd6, 32'h0);
        wr(3'd0, 32'h0004_0000);
        ev_direct = 4'b0100; tick(); clear_events();
        chk(!irq, "R9 masked bit keeps irq low", {31'b0, irq}, 32'h0);
        rd_chk(3'd0, 32'h0F04_1980, "R9 status latches while masked");
        wr(3'd6, 32'h0004_0000);
        chk(irq, "R9 irq after unmask", {31'b0, irq}, 32'h1);

        // R10: address 7, same-cycle read/write, no read side effects
        wr(3'd7, 32'hFFFF_FFFF);
        rd_chk(3'd7, 32'h0, "R10 address 7 reads zero");
        reg_rd = 1'b1; reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h10;
        tick();
        reg_rd = 1'b0; reg_wr = 1'b0;
        chk(reg_rdata == 32'h10, "R10 read returns pre-write value", reg_rdata, 32'h10);
        rd_chk(3'd5, 32'h0, "R10 write took effect");
        rd_chk(3'd4, 32'h0200_0001, "R10 read has no side effect");
        rd_chk(3'd4, 32'h0200_0001, "R10 repeated read stable");

        // R1: reset after activity
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk(!irq, "R1 irq after reset", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 7; a++) rd_chk(3'(a), 32'h0, "R1 cleared by reset");

        // Random traffic against the model (R6, R7, R8, R9, R10)
        for (int n = 0; n < 4000; n++) begin
            chk(irq == |(m_prim() & m_mask), "R9 random irq", {31'b0, irq},
                {31'b0, |(m_prim() & m_mask)});
            chk(reg_rvalid == m_rvalid, "R10 random rvalid", {31'b0, reg_rvalid},
                {31'b0, m_rvalid});
            if (m_rvalid) chk(reg_rdata == m_rdata, "R10 random readback", reg_rdata, m_rdata);
            v = $urandom;
            ev_txok   = (v[2:0] == 0) ? NQ'($urandom) : '0;
            ev_txdesc = (v[5:3] == 0) ? NQ'($urandom) : '0;
            ev_txerr  = (v[8:6] == 0) ? NQ'($urandom) : '0;
            ev_txeol  = (v[11:9] == 0) ? NQ'($urandom) : '0;
            ev_txurn  = (v[14:12] == 0) ? NQ'($urandom) : '0;
            ev_cbrovr = (v[17:15] == 0) ? NQ'($urandom) : '0;
            ev_cbrund = (v[20:18] == 0) ? NQ'($urandom) : '0;
            ev_qtrig  = (v[23:21] == 0) ? NQ'($urandom) : '0;
            ev_bus    = (v[25:24] == 0) ? 3'($urandom) : '0;
            ev_bcn    = (v[27:26] == 0) ? 7'($urandom) : '0;
            ev_direct = (v[29:28] == 0) ? 4'($urandom) : '0;
            reg_wr    = ($urandom % 4) == 0;
            reg_rd    = ($urandom % 3) == 0;
            reg_addr  = 3'($urandom);
            reg_wdata = $urandom & $urandom;
            tick();
        end
        reg_wr = 1'b0; reg_rd = 1'b0; clear_events();
        finish_run();
    end

endmodule